// File: doc/BRIEF.md
# Transmit Character Source Selector

This block sits at the front of one transmit channel and decides, every character clock, what goes to the line encoder. A registered input word (an 8-bit byte, a 2-bit control code, a 2-bit mode, a phase-error flag and a self-test enable) is captured on every clock. One clock later the block produces an output character. That character is either a raw 10-bit pre-encoded value for a bypassed encoder, or a byte tagged as data, special (K) or code violation for a downstream 8b/10b encoder.

Several sources compete for the output. A phase-error flag forces the violation character C0.7 and overrides everything else. A self-test enable replaces the traffic with a 511-character pseudo-random pattern. A word-sync request, when the atomic mode is selected, starts a run of 16 K28.5 characters that new input cannot break. Otherwise the captured register contents are used. Input words captured while a sync run is in progress are discarded, and the block flags each one.

Top module: `tx_char_source_sel`

## Requirements
- R1: While `rst_n` is low, the outputs are `kind_o`=3 (raw), `char_o`=0 and `drop_o`=0.
- R2: Mode bit 1 low selects encoder bypass. A word captured at clock edge N appears at edge N+1 with `kind_o`=3 and `char_o`={ctl, data}, with ctl in bits 9:8.
- R3: In encoded mode (mode bit 1 high), control code 00 gives `kind_o`=0 (data) and `char_o`={2'b00, data}.
- R4: In encoded mode, control code 01 gives `kind_o`=1 (special) and `char_o`={2'b00, data}, where the byte names the K code.
- R5: In encoded mode, control code 11 requests the violation character: `kind_o`=2 and `char_o`=10'h0E0 (C0.7).
- R6: In encoded mode with mode bit 0 low, control code 10 gives a single K28.5: `kind_o`=1 and `char_o`=10'h0BC.
- R7: In encoded mode with mode bit 0 high, control code 10 starts an atomic sync run. It occupies 16 consecutive output slots. Each slot is K28.5 (`kind_o`=1, `char_o`=10'h0BC) unless a higher-priority source overrides it.
- R8: A captured phase-error flag forces `kind_o`=2 and `char_o`=10'h0E0 on the next output, ahead of every other source.
- R9: A captured self-test enable, when no phase error is present, gives `kind_o`=0 and `char_o`={2'b00, state[7:0]} of a 9-bit LFSR. The LFSR shifts left, feeding state[8]^state[4] into bit 0 (x^9+x^5+1). This output takes precedence over a sync run and over the register contents.
- R10: The LFSR holds the seed 9'h1FF while self-test is off, and advances once per clock while it is on. The first self-test character is therefore 8'hFF, and the pattern repeats exactly every 511 characters.
- R11: `drop_o` is 1 in the output slot of each word captured during slots 2 to 16 of a sync run, and 0 otherwise. The run keeps counting while a phase error or self-test overrides its slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Bit 1: encoder enabled; bit 0: atomic sync runs |
| data_i | input | 8 | Data byte or K-code byte |
| ctl_i | input | 2 | Control code: 00 data, 01 special, 10 sync, 11 violation |
| phase_err_i | input | 1 | Phase-alignment error flag |
| bist_en_i | input | 1 | Self-test pattern enable |
| kind_o | output | 2 | 0 data, 1 special, 2 violation, 3 raw |
| char_o | output | 10 | Raw character, or byte in bits 7:0 |
| drop_o | output | 1 | Captured word discarded by a sync run |

## Verification
The assertions take for granted that all inputs are synchronous to `clk` and stay stable around the edge. They also assume that `mode_i` is sampled each clock like the data, so a mode change takes effect on the word captured with it. The stimulus changes inputs one nanosecond after each rising edge. It draws modes, control codes, phase errors and self-test runs from a seeded generator, so sync runs overlap phase errors, self-test and sync requests that arrive mid-run.

// File: rtl/txsel_pkg.sv
package txsel_pkg;

    localparam int BYTE_W     = 8;
    localparam int CTL_W      = 2;
    localparam int CHAR_W     = BYTE_W + CTL_W;
    localparam int MODE_ENC   = 1;
    localparam int MODE_SYNC  = 0;

    localparam logic [BYTE_W-1:0] BYTE_K28_5 = 8'hBC;
    localparam logic [BYTE_W-1:0] BYTE_C0_7  = 8'hE0;

    typedef enum logic [1:0] {
        KIND_DATA    = 2'd0,
        KIND_SPECIAL = 2'd1,
        KIND_VIOL    = 2'd2,
        KIND_RAW     = 2'd3
    } char_kind_e;

    typedef enum logic [CTL_W-1:0] {
        CTL_DATA    = 2'd0,
        CTL_SPECIAL = 2'd1,
        CTL_SYNC    = 2'd2,
        CTL_VIOL    = 2'd3
    } ctl_code_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [CTL_W-1:0]  ctl;
        logic [1:0]        mode;
        logic              perr;
        logic              bist;
    } in_word_t;

    typedef struct packed {
        char_kind_e        kind;
        logic [CHAR_W-1:0] chr;
        logic              drop;
    } out_word_t;

endpackage

// File: rtl/txsel_prbs.sv
module txsel_prbs #(
    parameter int             W    = 9,
    parameter int             TAP  = 5,
    parameter logic [W-1:0]   SEED = '1,
    parameter int             OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    output logic [OUT_W-1:0] pattern_o
);

    logic [W-1:0] state_d, state_q;

    always_comb begin
        if (en_i) begin
            state_d = {state_q[W-2:0], state_q[W-1] ^ state_q[TAP-1]};
        end else begin
            state_d = SEED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign pattern_o = state_q[OUT_W-1:0];

    AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);                                                    // R10

    AST_PRBS_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state_q == SEED);                                        // R10

    AST_PRBS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> state_q[W-1:1] == $past(state_q[W-2:0]));                 // R9

endmodule

// File: rtl/txsel_sync.sv
module txsel_sync #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CNT_W = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

    AST_SYNC_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);                  // R7

    AST_SYNC_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> cnt_q == '0);                                          // R7

    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> cnt_q == CNT_LOAD);                                    // R7

endmodule

// File: rtl/tx_char_source_sel.sv
module tx_char_source_sel
    import txsel_pkg::*;
#(
    parameter int            SYNC_LEN  = 16,
    parameter int            PRBS_W    = 9,
    parameter int            PRBS_TAP  = 5,
    parameter logic [PRBS_W-1:0] PRBS_SEED = '1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_i,
    input  logic [7:0]  data_i,
    input  logic [1:0]  ctl_i,
    input  logic        phase_err_i,
    input  logic        bist_en_i,
    output logic [1:0]  kind_o,
    output logic [9:0]  char_o,
    output logic        drop_o
);

    typedef struct packed {
        in_word_t  inw;
        out_word_t outw;
    } sel_state_t;

    sel_state_t        st_d, st_q;
    logic              sync_start;
    logic              sync_busy;
    logic [BYTE_W-1:0] prbs_byte;

    txsel_prbs #(
        .W     (PRBS_W),
        .TAP   (PRBS_TAP),
        .SEED  (PRBS_SEED),
        .OUT_W (BYTE_W)
    ) u_prbs (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (st_q.inw.bist),
        .pattern_o (prbs_byte)
    );

    txsel_sync #(
        .LEN (SYNC_LEN)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sync_start),
        .busy_o  (sync_busy)
    );

    always_comb begin
        st_d       = st_q;
        sync_start = 1'b0;

        st_d.inw.data = data_i;
        st_d.inw.ctl  = ctl_i;
        st_d.inw.mode = mode_i;
        st_d.inw.perr = phase_err_i;
        st_d.inw.bist = bist_en_i;

        st_d.outw.drop = sync_busy;

        if (st_q.inw.perr) begin
            st_d.outw.kind = KIND_VIOL;
            st_d.outw.chr  = {{CTL_W{1'b0}}, BYTE_C0_7};
        end else if (st_q.inw.bist) begin
            st_d.outw.kind = KIND_DATA;
            st_d.outw.chr  = {{CTL_W{1'b0}}, prbs_byte};
        end else if (sync_busy) begin
            st_d.outw.kind = KIND_SPECIAL;
            st_d.outw.chr  = {{CTL_W{1'b0}}, BYTE_K28_5};
        end else if (!st_q.inw.mode[MODE_ENC]) begin
            st_d.outw.kind = KIND_RAW;
            st_d.outw.chr  = {st_q.inw.ctl, st_q.inw.data};
        end else begin
            unique case (ctl_code_e'(st_q.inw.ctl))
                CTL_DATA: begin
                    st_d.outw.kind = KIND_DATA;
                    st_d.outw.chr  = {{CTL_W{1'b0}}, st_q.inw.data};
                end
                CTL_SPECIAL: begin
                    st_d.outw.kind = KIND_SPECIAL;
                    st_d.outw.chr  = {{CTL_W{1'b0}}, st_q.inw.data};
                end
                CTL_SYNC: begin
                    st_d.outw.kind = KIND_SPECIAL;
                    st_d.outw.chr  = {{CTL_W{1'b0}}, BYTE_K28_5};
                    sync_start     = st_q.inw.mode[MODE_SYNC];
                end
                default: begin
                    st_d.outw.kind = KIND_VIOL;
                    st_d.outw.chr  = {{CTL_W{1'b0}}, BYTE_C0_7};
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.outw.kind <= KIND_RAW;
        end else begin
            st_q <= st_d;
        end
    end

    assign kind_o = st_q.outw.kind;
    assign char_o = st_q.outw.chr;
    assign drop_o = st_q.outw.drop;

    AST_PERR_FORCES_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.inw.perr |=> (kind_o == KIND_VIOL && char_o == 10'h0E0));     // R8

    AST_BIST_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.inw.bist && !st_q.inw.perr) |=> kind_o == KIND_DATA);        // R9

    AST_SYNC_SLOT_K: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_busy && !st_q.inw.perr && !st_q.inw.bist)
        |=> (kind_o == KIND_SPECIAL && char_o == 10'h0BC));                // R7

    AST_DROP_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sync_busy |=> drop_o);                                             // R11

    AST_NO_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_busy |=> !drop_o);                                           // R11

    AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.inw.perr && !st_q.inw.bist && !sync_busy && !st_q.inw.mode[MODE_ENC])
        |=> (kind_o == KIND_RAW
             && char_o == $past({st_q.inw.ctl, st_q.inw.data})));          // R2

endmodule

// File: tb/tx_char_source_sel_tb.sv
module tx_char_source_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_i;
    logic [7:0] data_i;
    logic [1:0] ctl_i;
    logic       phase_err_i;
    logic       bist_en_i;
    logic [1:0] kind_o;
    logic [9:0] char_o;
    logic       drop_o;

    always #5 clk = ~clk;

    tx_char_source_sel u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .data_i      (data_i),
        .ctl_i       (ctl_i),
        .phase_err_i (phase_err_i),
        .bist_en_i   (bist_en_i),
        .kind_o      (kind_o),
        .char_o      (char_o),
        .drop_o      (drop_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state, built from the requirement text
    logic [7:0] mi_data;
    logic [1:0] mi_ctl;
    logic [1:0] mi_mode;
    logic       mi_perr;
    logic       mi_bist;
    int         m_cnt;
    logic [8:0] m_lfsr;
    logic [1:0] e_kind;
    logic [9:0] e_char;
    logic       e_drop;
    string      e_tag;

    logic [7:0] bist_buf [0:1021];
    int         bist_idx;

    function automatic logic [8:0] lfsr_next(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mi_data = '0; mi_ctl = '0; mi_mode = '0; mi_perr = 1'b0; mi_bist = 1'b0;
        m_cnt = 0; m_lfsr = 9'h1FF;
    endtask

    task automatic model_step();
        bit busy;
        bit start;
        busy   = (m_cnt != 0);
        start  = 1'b0;
        e_drop = busy;
        if (mi_perr) begin
            e_kind = 2'd2; e_char = 10'h0E0; e_tag = "R8";
        end else if (mi_bist) begin
            e_kind = 2'd0; e_char = {2'b00, m_lfsr[7:0]}; e_tag = "R9";
        end else if (busy) begin
            e_kind = 2'd1; e_char = 10'h0BC; e_tag = "R7";
        end else if (!mi_mode[1]) begin
            e_kind = 2'd3; e_char = {mi_ctl, mi_data}; e_tag = "R2";
        end else begin
            case (mi_ctl)
                2'd0: begin e_kind = 2'd0; e_char = {2'b00, mi_data}; e_tag = "R3"; end
                2'd1: begin e_kind = 2'd1; e_char = {2'b00, mi_data}; e_tag = "R4"; end
                2'd3: begin e_kind = 2'd2; e_char = 10'h0E0; e_tag = "R5"; end
                default: begin
                    e_kind = 2'd1; e_char = 10'h0BC;
                    start  = mi_mode[0];
                    e_tag  = mi_mode[0] ? "R7" : "R6";
                end
            endcase
        end
        if (start) m_cnt = 15;
        else if (busy) m_cnt = m_cnt - 1;
        m_lfsr = mi_bist ? lfsr_next(m_lfsr) : 9'h1FF;
        mi_data = data_i; mi_ctl = ctl_i; mi_mode = mode_i;
        mi_perr = phase_err_i; mi_bist = bist_en_i;
    endtask

    // one clock: inputs already set; sample 1 ns after the edge
    task automatic cycle();
        @(posedge clk);
        #1;
        model_step();
        check(e_tag, "kind", {14'd0, kind_o}, {14'd0, e_kind});
        check(e_tag, "char", {6'd0, char_o}, {6'd0, e_char});
        check("R11", "drop", {15'd0, drop_o}, {15'd0, e_drop});
    endtask

    task automatic drive(input logic [1:0] m, input logic [1:0] c,
                         input logic [7:0] d, input logic pe, input logic be);
        mode_i = m; ctl_i = c; data_i = d; phase_err_i = pe; bist_en_i = be;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        drive(2'b11, 2'b10, 8'h5A, 1'b1, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state while inputs are active
        check("R1", "kind", {14'd0, kind_o}, 16'd3);
        check("R1", "char", {6'd0, char_o}, 16'd0);
        check("R1", "drop", {15'd0, drop_o}, 16'd0);
        rst_n = 1'b1;
        model_reset();
        drive(2'b00, 2'b00, 8'h00, 1'b0, 1'b0);

        // R2: bypass, raw passthrough with control bits on top
        drive(2'b00, 2'b11, 8'hA5, 1'b0, 1'b0); cycle();
        drive(2'b01, 2'b10, 8'h3C, 1'b0, 1'b0); cycle();
        drive(2'b00, 2'b01, 8'hFF, 1'b0, 1'b0); cycle();
        // R3 R4 R5 R6: encoded codes, single K28.5 without atomic mode
        drive(2'b10, 2'b00, 8'h12, 1'b0, 1'b0); cycle();
        drive(2'b10, 2'b01, 8'hFB, 1'b0, 1'b0); cycle();
        drive(2'b10, 2'b11, 8'h77, 1'b0, 1'b0); cycle();
        drive(2'b10, 2'b10, 8'h44, 1'b0, 1'b0); cycle();
        drive(2'b10, 2'b10, 8'h45, 1'b0, 1'b0); cycle();
        drive(2'b10, 2'b00, 8'h99, 1'b0, 1'b0); cycle();
        cycle();
        // R7 R11: atomic run with new requests and a phase error inside it
        drive(2'b11, 2'b10, 8'h00, 1'b0, 1'b0); cycle();
        for (int i = 0; i < 20; i++) begin
            drive(2'b11, (i == 3) ? 2'b10 : 2'b00, 8'(i), (i == 6), 1'b0);
            cycle();
        end
        // R8: phase error beats a sync request and self-test
        drive(2'b11, 2'b10, 8'h01, 1'b1, 1'b1); cycle();
        drive(2'b10, 2'b00, 8'h02, 1'b0, 1'b0); cycle(); cycle();

        // R9 R10: long self-test run, seed and period
        bist_idx = 0;
        for (int i = 0; i < 1030; i++) begin
            drive(2'($urandom), 2'($urandom), 8'($urandom), 1'b0, 1'b1);
            cycle();
            if (e_tag == "R9" && bist_idx < 1022) begin
                bist_buf[bist_idx] = char_o[7:0];
                bist_idx++;
            end
        end
        check("R10", "first self-test byte", {8'd0, bist_buf[0]}, 16'h00FF);
        begin
            int mism = 0;
            for (int i = 0; i < 511; i++)
                if (bist_buf[i] !== bist_buf[i + 511]) mism++;
            check("R10", "period-511 mismatches", 16'(mism), 16'd0);
        end
        drive(2'b10, 2'b00, 8'h10, 1'b0, 1'b0); cycle(); cycle();

        // random mix across all sources
        begin
            logic [1:0] rm = 2'b11;
            logic       rb = 1'b0;
            for (int i = 0; i < 6000; i++) begin
                if ($urandom_range(0, 39) == 0) rm = 2'($urandom);
                if ($urandom_range(0, 149) == 0) rb = ~rb;
                drive(rm, 2'($urandom), 8'($urandom),
                      ($urandom_range(0, 19) == 0), rb);
                cycle();
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule